// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores incoming frames in host memory by way of a ring of sixteen receive descriptors. Each descriptor is four 16-bit words at `ring_base + 4*index`. Word 0 holds the low 16 bits of the buffer word address. Word 1 holds the status flags in its low byte and the high buffer-address byte in its high byte. Word 2 holds the buffer size as a negative two's-complement count, which the host maintains and this block does not read. Word 3 receives the stored byte count. A descriptor is handed to the block by setting its flags byte to exactly `0x80` (owned).

When a frame starts, the block searches forward from its ring pointer for an owned descriptor. It then reads the buffer address and streams the frame into the buffer, two bytes per memory word. It pads the frame with zeros, writes the length, and returns the descriptor to the host with a final flags write. It then pulses a receive-interrupt strobe and moves its pointer past the used slot.

While it waits between frames, the block polls every descriptor's flags. This keeps a `can_receive` output that tells the frame source whether any slot is free.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `can_receive`, `rint` and `in_ready` are 0 and the ring pointer is 0.
- R2: While `stopped` is 0, `can_receive` becomes 1 within 40 cycles of any descriptor's flags byte being exactly 0x80 with no frame in progress. It is 0 in the cycle after any cycle with `stopped` at 1.
- R3: The search for a frame begins at the ring pointer and takes the first descriptor whose flags byte equals exactly 0x80. A descriptor with any other flags value (for example 0x81) is skipped and left unchanged.
- R4: Frame byte 2k is stored in bits 7:0 and byte 2k+1 in bits 15:8 of the word at buffer address `{hi, lo} + k`. Here hi is bits 15:8 of descriptor word 1 and lo is descriptor word 0.
- R5: A frame shorter than `MIN_BYTES` (60) is padded with zero bytes up to `MIN_BYTES`, and its stored length is `MIN_BYTES`. If a frame has an odd byte count, the upper byte of its last word is zero.
- R6: Descriptor word 3 receives the stored length. Word 1 becomes `{hi, 8'h03}` (start- and end-of-packet set, owned bit 0x80 clear), with the high address byte unchanged.
- R7: Bytes beyond `BUF_BYTES` are discarded and never written. The length is `BUF_BYTES`, and the flags byte is 0x53, which adds overflow 0x10 and error 0x40.
- R8: For each frame the length word is written before the flags word, and the flags write is the last memory write of the frame.
- R9: `rint` is a one-cycle pulse, issued once per stored frame in the cycle after the flags write. The ring pointer becomes the used index plus one, modulo 16, so slot 15 is followed by slot 0.
- R10: If none of the 16 descriptors is owned, the frame is consumed with no memory write and no `rint`.
- R11: A frame that begins while `stopped` is 1 is consumed with no memory write and no `rint`, and the ring pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stopped | input | 1 | Controller stopped; new frames are dropped |
| ring_base | input | ADDR_W | Word address of descriptor 0 |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |
| can_receive | output | 1 | Some descriptor is known to be owned and the block is not stopped |
| rint | output | 1 | One-cycle receive-interrupt strobe |

## Verification
Frames of length 64, 61, 10 and 90 bytes are sent against an 80-byte buffer. These lengths separate even and odd packing, zero padding to the minimum, and truncation with overflow flags. Owned slots are placed after a non-exact flags value and behind a run of unowned slots, which shows that only an exact 0x80 match is taken and that the search wraps from slot 15 to slot 0. A ring with no owned slot and a stopped controller show that frames are consumed without touching memory, with the pointer kept for the next frame.

// File: rtl/rxr_pkg.sv
// Shared constants and types for the receive ring writer.
package rxr_pkg;
    localparam logic [7:0] FL_OWN = 8'h80;
    localparam logic [7:0] FL_ERR = 8'h40;
    localparam logic [7:0] FL_OFL = 8'h10;
    localparam logic [7:0] FL_SOP = 8'h02;
    localparam logic [7:0] FL_EOP = 8'h01;

    localparam logic [1:0] FLD_ADDR_LO = 2'd0;
    localparam logic [1:0] FLD_FLAGS   = 2'd1;
    localparam logic [1:0] FLD_MSGLEN  = 2'd3;

    typedef enum logic [3:0] {
        S_IDLE, S_POLL, S_SRCH_RD, S_SRCH_CHK, S_ADR_RD, S_ADR_CAP,
        S_DATA, S_PAD, S_LEN, S_FLAG, S_DROP
    } rxr_state_t;
endpackage

// File: rtl/rxr_own_map.sv
// Shadow of which descriptors are host-owned, updated from flag reads and
// cleared when a slot is handed back. Assumes one update per cycle at most.
module rxr_own_map #(
    parameter int RING_LOG2 = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stopped,
    input  logic                 upd_en,
    input  logic [RING_LOG2-1:0] upd_idx,
    input  logic                 upd_val,
    output logic                 can_receive
);
    localparam int RING_N = 1 << RING_LOG2;

    logic [RING_N-1:0] own_vec;

    for (genvar g = 0; g < RING_N; g++) begin : g_entry
        // Per-entry ownership flop, written when its index is updated.
        always_ff @(posedge clk) begin
            if (!rst_n)
                own_vec[g] <= 1'b0;
            else if (upd_en && upd_idx == RING_LOG2'(g))
                own_vec[g] <= upd_val;
        end
    end

    // Registered availability, forced low while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            can_receive <= 1'b0;
        else
            can_receive <= !stopped && (|own_vec);
    end
endmodule

// File: rtl/rxr_fill.sv
// Packs accepted bytes into 16-bit words, truncates at the buffer size,
// then pads to the minimum length. Assumes BUF_BYTES is even and at least
// MIN_BYTES.
module rxr_fill #(
    parameter int BUF_BYTES = 1544,
    parameter int MIN_BYTES = 60,
    parameter int CNT_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [7:0]       data,
    input  logic             last,
    input  logic             pad_go,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_off,
    output logic [15:0]      wr_data,
    output logic             pad_done,
    output logic [CNT_W-1:0] len,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] BUF_C = CNT_W'(BUF_BYTES);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_BYTES);

    logic [CNT_W-1:0] cnt;
    logic [7:0]       hold;
    logic             room;
    logic [CNT_W-1:0] cnt_next;

    assign room     = cnt < BUF_C;
    assign cnt_next = room ? cnt + 1'b1 : cnt;
    assign pad_done = !cnt[0] && (cnt >= len);

    // Word write request for data pairs and for padding steps.
    always_comb begin
        wr_en   = 1'b0;
        wr_off  = cnt >> 1;
        wr_data = 16'h0000;
        if (take && room && cnt[0]) begin
            wr_en   = 1'b1;
            wr_data = {data, hold};
        end else if (pad_go) begin
            if (cnt[0]) begin
                wr_en   = 1'b1;
                wr_data = {8'h00, hold};
            end else if (cnt < len) begin
                wr_en = 1'b1;
            end
        end
    end

    // Byte counter, low-byte holder, length and overflow capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt  <= '0;
            hold <= 8'h00;
            len  <= '0;
            ovf  <= 1'b0;
        end else if (take) begin
            if (room) begin
                if (!cnt[0]) hold <= data;
                cnt <= cnt + 1'b1;
            end else begin
                ovf <= 1'b1;
            end
            if (last) len <= (cnt_next < MIN_C) ? MIN_C : cnt_next;
        end else if (pad_go) begin
            if (cnt[0])         cnt <= cnt + 1'b1;
            else if (cnt < len) cnt <= cnt + 2'd2;
        end
    end
endmodule

// File: rtl/rx_ring_writer.sv
// Receive descriptor ring writer: finds an owned descriptor, stores the
// frame into its buffer, writes the length then the flags, pulses rint.
// Assumes memory reads return data one cycle after the request.
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int RING_LOG2 = 4,
    parameter int BUF_BYTES = 1544,
    parameter int MIN_BYTES = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stopped,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              can_receive,
    output logic              rint
);
    localparam int RING_N = 1 << RING_LOG2;
    localparam int CNT_W  = $clog2(BUF_BYTES + 1) + 1;

    rxr_state_t           state;
    logic [RING_LOG2-1:0] rxptr, poll_idx, srch_idx, srch_n;
    logic [7:0]           buf_hi;
    logic [15:0]          buf_lo;
    logic                 rd_own;

    logic             f_wr_en, f_pad_done, f_ovf;
    logic [CNT_W-1:0] f_wr_off, f_len;
    logic [15:0]      f_wr_data;

    logic                 upd_en, upd_val;
    logic [RING_LOG2-1:0] upd_idx;

    assign rd_own = (mem_rdata[7:0] == FL_OWN);

    function automatic logic [ADDR_W-1:0] desc_addr(
        input logic [ADDR_W-1:0] base, input logic [RING_LOG2-1:0] idx,
        input logic [1:0] fld);
        return base + ADDR_W'({idx, 2'b00}) + ADDR_W'(fld);
    endfunction

    rxr_fill #(.BUF_BYTES(BUF_BYTES), .MIN_BYTES(MIN_BYTES), .CNT_W(CNT_W)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .clr(state == S_ADR_CAP),
        .take(state == S_DATA && in_valid),
        .data(in_data), .last(in_last),
        .pad_go(state == S_PAD && !f_pad_done),
        .wr_en(f_wr_en), .wr_off(f_wr_off), .wr_data(f_wr_data),
        .pad_done(f_pad_done), .len(f_len), .ovf(f_ovf)
    );

    // Ownership updates come from poll reads, search reads and hand-back.
    always_comb begin
        upd_en  = (state == S_POLL) || (state == S_SRCH_CHK) || (state == S_FLAG);
        upd_idx = (state == S_POLL) ? poll_idx : srch_idx;
        upd_val = (state == S_FLAG) ? 1'b0 : rd_own;
    end

    rxr_own_map #(.RING_LOG2(RING_LOG2)) u_own (
        .clk(clk), .rst_n(rst_n), .stopped(stopped),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_val(upd_val),
        .can_receive(can_receive)
    );

    // Memory request and input handshake selected by the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = 16'h0000;
        in_ready  = 1'b0;
        case (state)
            S_IDLE: if (!in_valid) begin
                mem_req  = 1'b1;
                mem_addr = desc_addr(ring_base, poll_idx, FLD_FLAGS);
            end
            S_SRCH_RD: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr(ring_base, srch_idx, FLD_FLAGS);
            end
            S_ADR_RD: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr(ring_base, srch_idx, FLD_ADDR_LO);
            end
            S_DATA, S_PAD: begin
                in_ready  = (state == S_DATA);
                mem_req   = f_wr_en;
                mem_we    = f_wr_en;
                mem_addr  = ADDR_W'({buf_hi, buf_lo}) + ADDR_W'(f_wr_off);
                mem_wdata = f_wr_data;
            end
            S_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr(ring_base, srch_idx, FLD_MSGLEN);
                mem_wdata = 16'(f_len);
            end
            S_FLAG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr(ring_base, srch_idx, FLD_FLAGS);
                mem_wdata = {buf_hi, FL_SOP | FL_EOP | (f_ovf ? (FL_OFL | FL_ERR) : 8'h00)};
            end
            S_DROP: in_ready = 1'b1;
            default: ;
        endcase
    end

    // Sequencer: poll, search, address fetch, data, pad, length, flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            rxptr    <= '0;
            poll_idx <= '0;
            srch_idx <= '0;
            srch_n   <= '0;
            buf_hi   <= 8'h00;
            buf_lo   <= 16'h0000;
            rint     <= 1'b0;
        end else begin
            rint <= (state == S_FLAG);
            case (state)
                S_IDLE: begin
                    if (in_valid) begin
                        if (stopped) begin
                            state <= S_DROP;
                        end else begin
                            srch_idx <= rxptr;
                            srch_n   <= '0;
                            state    <= S_SRCH_RD;
                        end
                    end else begin
                        state <= S_POLL;
                    end
                end
                S_POLL: begin
                    poll_idx <= poll_idx + 1'b1;
                    state    <= S_IDLE;
                end
                S_SRCH_RD: state <= S_SRCH_CHK;
                S_SRCH_CHK: begin
                    if (rd_own) begin
                        buf_hi <= mem_rdata[15:8];
                        state  <= S_ADR_RD;
                    end else if (srch_n == RING_LOG2'(RING_N - 1)) begin
                        state <= S_DROP;
                    end else begin
                        srch_idx <= srch_idx + 1'b1;
                        srch_n   <= srch_n + 1'b1;
                        state    <= S_SRCH_RD;
                    end
                end
                S_ADR_RD: state <= S_ADR_CAP;
                S_ADR_CAP: begin
                    buf_lo <= mem_rdata;
                    state  <= S_DATA;
                end
                S_DATA: if (in_valid && in_last) state <= S_PAD;
                S_PAD:  if (f_pad_done) state <= S_LEN;
                S_LEN:  state <= S_FLAG;
                S_FLAG: begin
                    rxptr <= srch_idx + 1'b1;
                    state <= S_IDLE;
                end
                S_DROP: if (in_valid && in_last) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_ring_writer_chk.sv
// Port-level protocol checks for the receive ring writer.
module rx_ring_writer_chk #(
    parameter int ADDR_W    = 24,
    parameter int RING_LOG2 = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stopped,
    input logic [ADDR_W-1:0] ring_base,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata,
    input logic              can_receive,
    input logic              rint
);
    localparam int DESC_WORDS = 4 << RING_LOG2;

    logic [ADDR_W-1:0] off;
    logic              is_desc, wr, len_wr, flag_wr;
    logic              saw_len;

    assign off     = mem_addr - ring_base;
    assign is_desc = off < ADDR_W'(DESC_WORDS);
    assign wr      = mem_req && mem_we;
    assign len_wr  = wr && is_desc && off[1:0] == 2'd3;
    assign flag_wr = wr && is_desc && off[1:0] == 2'd1;

    // Tracks that a length write precedes the pending hand-back.
    always_ff @(posedge clk) begin
        if (!rst_n)       saw_len <= 1'b0;
        else if (len_wr)  saw_len <= 1'b1;
        else if (flag_wr) saw_len <= 1'b0;
    end

    p_len_before_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |-> saw_len);
    p_flags_clear_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |-> (mem_wdata[7] == 1'b0 && mem_wdata[1:0] == 2'b11));
    p_rint_after_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rint |-> $past(flag_wr));
    p_rint_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rint |=> !rint);
    p_stop_blocks_canrx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> !can_receive);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.ADDR_W(ADDR_W), .RING_LOG2(RING_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .stopped(stopped), .ring_base(ring_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .can_receive(can_receive), .rint(rint)
);

// File: tb/test_rx_ring_writer.sv
// Directed bench: a word memory model, one task per scenario.
module test_rx_ring_writer;
    localparam int ADDR_W = 24;
    localparam int BUFB   = 80;
    localparam int RING   = 16'h0010;
    localparam logic [7:0] HI = 8'hA5;

    logic clk = 1'b0, rst_n = 1'b0, stopped = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, mem_req, mem_we, can_receive, rint;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [ADDR_W-1:0] ring_base = ADDR_W'(RING);

    logic [15:0] mem [2048];
    int rint_cnt = 0, wr_cnt = 0;
    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    rx_ring_writer #(.ADDR_W(ADDR_W), .BUF_BYTES(BUFB), .MIN_BYTES(60)) i_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .stopped(stopped), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .can_receive(can_receive), .rint(rint)
    );

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[mem_addr[10:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[10:0]];
        if (rint) rint_cnt <= rint_cnt + 1;
    end

    function automatic int dsc(int i, int f);
        return RING + 4 * i + f;
    endfunction
    function automatic int slot(int i);
        return 16'h0100 + 64 * i;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic init_ring();
        for (int i = 0; i < 16; i++) begin
            mem[dsc(i, 0)] = 16'(slot(i));
            mem[dsc(i, 1)] = {HI, 8'h00};
            mem[dsc(i, 2)] = 16'(-BUFB);
            mem[dsc(i, 3)] = 16'h0000;
            for (int k = 0; k < 64; k++) mem[slot(i) + k] = 16'hFFFF;
        end
    endtask

    task automatic set_flags(int i, logic [7:0] f);
        mem[dsc(i, 1)] = {HI, f};
    endtask

    task automatic send_frame(int n, logic [7:0] seed);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = seed + 8'(j);
            in_last  = (j == n - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    // Compares a slot's buffer, length word and flags word to the rules.
    task automatic check_slot(int s, int n, logic [7:0] seed, logic [7:0] fl, string req);
        int stored, len, bad, first_k;
        logic [15:0] exp_w, first_a, first_e;
        stored = (n < BUFB) ? n : BUFB;
        len    = (stored < 60) ? 60 : stored;
        bad = 0; first_k = -1; first_a = 0; first_e = 0;
        for (int k = 0; k < 41; k++) begin
            for (int h = 0; h < 2; h++) begin
                int b = 2 * k + h;
                exp_w[8*h +: 8] = (b < stored) ? seed + 8'(b) : ((2 * k < len) ? 8'h00 : 8'hFF);
            end
            if (mem[slot(s) + k] !== exp_w) begin
                bad++;
                if (first_k < 0) begin first_k = k; first_a = mem[slot(s) + k]; first_e = exp_w; end
            end
        end
        check(bad == 0, {req, " buffer"}, int'(first_a), int'(first_e));
        check(mem[dsc(s, 3)] == 16'(len), {req, " length"}, int'(mem[dsc(s, 3)]), len);
        check(mem[dsc(s, 1)] == {HI, fl}, {req, " flags"}, int'(mem[dsc(s, 1)]), int'({HI, fl}));
    endtask

    task automatic t_reset();
        check(can_receive == 1'b0, "R1 can_receive", int'(can_receive), 0);
        check(rint == 1'b0, "R1 rint", int'(rint), 0);
        check(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
    endtask

    task automatic t_can_receive();
        repeat (40) @(negedge clk);
        check(can_receive == 1'b0, "R2 none owned", int'(can_receive), 0);
        set_flags(0, 8'h80);
        repeat (40) @(negedge clk);
        check(can_receive == 1'b1, "R2 owned seen", int'(can_receive), 1);
        stopped = 1'b1;
        repeat (2) @(negedge clk);
        check(can_receive == 1'b0, "R2 stopped", int'(can_receive), 0);
        stopped = 1'b0;
    endtask

    task automatic t_basic();
        int r0 = rint_cnt;
        send_frame(64, 8'h10);
        check_slot(0, 64, 8'h10, 8'h03, "R4 R6 even frame");
        check(rint_cnt == r0 + 1, "R9 one rint", rint_cnt - r0, 1);
    endtask

    task automatic t_skip_odd();
        set_flags(1, 8'h81);
        set_flags(2, 8'h80);
        send_frame(61, 8'h40);
        check_slot(2, 61, 8'h40, 8'h03, "R3 R5 skip/odd");
        check(mem[dsc(1, 1)] == {HI, 8'h81}, "R3 non-exact untouched", int'(mem[dsc(1, 1)]), int'({HI, 8'h81}));
    endtask

    task automatic t_short();
        set_flags(3, 8'h80);
        send_frame(10, 8'h70);
        check_slot(3, 10, 8'h70, 8'h03, "R5 padded short");
    endtask

    task automatic t_overflow();
        set_flags(4, 8'h80);
        send_frame(90, 8'h01);
        check_slot(4, 90, 8'h01, 8'h53, "R7 truncated");
    endtask

    task automatic t_wrap();
        set_flags(15, 8'h80);
        send_frame(20, 8'h90);
        check_slot(15, 20, 8'h90, 8'h03, "R9 slot 15");
        for (int k = 0; k < 64; k++) mem[slot(0) + k] = 16'hFFFF;
        set_flags(0, 8'h80);
        send_frame(66, 8'hC0);
        check_slot(0, 66, 8'hC0, 8'h03, "R9 wrap to 0");
    endtask

    task automatic t_none_owned();
        int r0 = rint_cnt, w0 = wr_cnt;
        for (int i = 0; i < 16; i++) set_flags(i, 8'h00);
        send_frame(20, 8'h22);
        check(rint_cnt == r0, "R10 no rint", rint_cnt - r0, 0);
        check(wr_cnt == w0, "R10 no write", wr_cnt - w0, 0);
    endtask

    task automatic t_stopped();
        int r0 = rint_cnt, w0 = wr_cnt;
        for (int k = 0; k < 64; k++) mem[slot(1) + k] = 16'hFFFF;
        set_flags(1, 8'h80);
        stopped = 1'b1;
        send_frame(30, 8'h33);
        check(rint_cnt == r0, "R11 no rint", rint_cnt - r0, 0);
        check(wr_cnt == w0, "R11 no write", wr_cnt - w0, 0);
        check(mem[dsc(1, 1)] == {HI, 8'h80}, "R11 desc kept", int'(mem[dsc(1, 1)]), int'({HI, 8'h80}));
        stopped = 1'b0;
        send_frame(30, 8'h33);
        check_slot(1, 30, 8'h33, 8'h03, "R11 pointer kept");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        init_ring();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_can_receive();
        t_basic();
        t_skip_odd();
        t_short();
        t_overflow();
        for (int i = 5; i < 15; i++) set_flags(i, 8'h00);
        t_wrap();
        t_none_owned();
        t_stopped();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule